// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recently used address translations so that most memory accesses skip the page-table walk. A requester presents a virtual page key made of a segment number and a page number. Every stored entry is compared with that key at once. When one matches, the physical page number comes back in the same cycle and no walk is started.

When nothing matches, the block raises a miss, latches the key and issues a request to an external table walker. It then waits on the walker's response handshake, because a walk can take anywhere from a few cycles to hundreds. A successful response is written into a free slot or, if all slots are full, over the least recently used one. The response is also passed back to the requester. A fault response is passed back without installing anything. A flush input invalidates every entry in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: When `lk_ready` is 1 and a lookup key matches a valid entry, with no flush in that cycle, `lk_hit` is 1 and `lk_ppn` holds that entry's physical page number in the same cycle. `lk_miss` is 0 and no walk request follows.
- R2: When `lk_ready` is 1, `lk_valid` is 1 and no valid entry matches, `lk_miss` is 1 in that cycle. From the next cycle `wk_req` is 1 with `wk_seg`/`wk_vpn` equal to the missed key, held stable until the cycle in which `wk_rsp_valid` is 1.
- R3: The cycle after the walker response is accepted, `res_valid` pulses for one cycle carrying the walker's page number and fault flag, and `lk_ready` returns to 1. A non-fault response is installed, so the next lookup of that key hits with that page number.
- R4: A response with `wk_rsp_fault` = 1 gives `res_fault` = 1 and installs nothing: a later lookup of the same key misses again.
- R5: While a walk is outstanding, `lk_ready` is 0 and lookups are ignored: `lk_hit` and `lk_miss` stay 0 and the request key does not change.
- R6: A free entry is always used before any valid entry is evicted: after a flush, ENTRIES fills of distinct keys all remain resident.
- R7: When all entries are valid, a fill replaces the least recently used entry, where both a hit and a fill make an entry the most recently used.
- R8: `flush` = 1 invalidates every entry by the next cycle. A lookup presented in the flush cycle is treated as a miss and starts a walk.
- R9: If `flush` is 1 in the same cycle that the walker response is accepted, the response is still returned on `res_*` but is not installed.
- R10: After reset no entry is valid, `lk_ready` is 1, and `wk_req` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup presented |
| lk_seg | input | SEG_W | Lookup segment number |
| lk_vpn | input | VPN_W | Lookup page number |
| lk_ready | output | 1 | No walk outstanding; lookups accepted |
| lk_hit | output | 1 | Lookup matched an entry (same cycle) |
| lk_miss | output | 1 | Lookup missed; walk begins |
| lk_ppn | output | PPN_W | Physical page number on a hit, else 0 |
| wk_req | output | 1 | Walk request, held until response |
| wk_seg | output | SEG_W | Segment number being walked |
| wk_vpn | output | VPN_W | Page number being walked |
| wk_rsp_valid | input | 1 | Walker response strobe |
| wk_rsp_ppn | input | PPN_W | Walker physical page number |
| wk_rsp_fault | input | 1 | Walker reports a fault |
| res_valid | output | 1 | Miss result pulse |
| res_ppn | output | PPN_W | Miss result page number |
| res_fault | output | 1 | Miss result fault flag |

## Verification
A wrong valid bit or stored key appears at the ports at the first lookup of the affected key: a hit turns into a miss with a walk request one cycle later, or a miss turns into a hit. A wrong stored page number appears as a wrong `lk_ppn` in the same cycle as the hit. Corrupt recency state does nothing visible until the buffer is full. It then evicts the wrong entry, and this only shows up on the later lookup of the entry that should have stayed or should have gone. The tests therefore fill the buffer, reorder it with hits, and probe both the survivor and the victim.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } tlb_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 16,
  parameter int KEY_W = 12,
  parameter int PPN_W = 12,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [KEY_W-1:0] key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [PPN_W-1:0] wr_ppn,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx,
  output logic [PPN_W-1:0] hit_ppn,
  output logic [N-1:0]     valid_vec
);
  logic [KEY_W-1:0] key_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     valid_q;
  logic [N-1:0]     hit_vec;

  // payload arrays: no reset, single write port
  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_q[wr_idx] <= wr_key;
      ppn_q[wr_idx] <= wr_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (wr_en)   valid_q[wr_idx] <= 1'b1;
  end

  // parallel compare, one comparator per slot
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = valid_q[i] && (key_q[i] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign hit       = |hit_vec;
  assign hit_ppn   = ppn_q[hit_idx];
  assign valid_vec = valid_q;

  // a key is never resident twice
  p_hit_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [N-1:0]     valid_vec,
  output logic [IDX_W-1:0] victim_idx
);
  // age 0 = most recent, N-1 = least recent; ages always form a permutation
  logic [IDX_W-1:0] age_q [N];
  logic [N-1:0]     oldest_vec;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] old_idx;
  logic             any_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_old
    assign oldest_vec[i] = (age_q[i] == IDX_W'(N - 1));
  end

  // lowest-numbered free slot, otherwise the oldest slot
  always_comb begin
    free_idx = '0;
    old_idx  = '0;
    any_free = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
      if (oldest_vec[i]) old_idx = IDX_W'(i);
    end
  end

  assign victim_idx = any_free ? free_idx : old_idx;

  p_one_oldest_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot(oldest_vec));
  p_touch_youngest_r7: assert property (@(posedge clk) disable iff (rst)
    touch |=> (age_q[$past(touch_idx)] == '0));
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int KEY_W = 12,
  parameter int PPN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [KEY_W-1:0] lk_key,
  input  logic             cam_hit,
  input  logic             rsp_valid,
  input  logic [PPN_W-1:0] rsp_ppn,
  input  logic             rsp_fault,
  output logic             lk_ready,
  output logic             lk_miss,
  output logic             wk_req,
  output logic [KEY_W-1:0] wk_key,
  output logic             fill_en,
  output logic             res_valid,
  output logic [PPN_W-1:0] res_ppn,
  output logic             res_fault
);
  tlb_state_e       state_q;
  logic [KEY_W-1:0] key_q;
  logic             accept;

  assign lk_ready = (state_q == ST_IDLE);
  assign lk_miss  = lk_ready && lk_valid && (!cam_hit || flush);
  assign accept   = (state_q == ST_WALK) && rsp_valid;
  assign fill_en  = accept && !rsp_fault && !flush;
  assign wk_req   = (state_q == ST_WALK);
  assign wk_key   = key_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      key_q     <= '0;
      res_valid <= 1'b0;
      res_ppn   <= '0;
      res_fault <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (lk_miss) begin
        state_q <= ST_WALK;
        key_q   <= lk_key;
      end else if (accept) begin
        state_q   <= ST_IDLE;
        res_valid <= 1'b1;
        res_ppn   <= rsp_ppn;
        res_fault <= rsp_fault;
      end
    end
  end

  p_miss_starts_walk_r2: assert property (@(posedge clk) disable iff (rst)
    lk_miss |=> (wk_req && wk_key == $past(lk_key)));
  p_req_held_r2: assert property (@(posedge clk) disable iff (rst)
    (wk_req && !rsp_valid) |=> (wk_req && $stable(wk_key)));
  p_res_single_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);
  p_res_frees_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> lk_ready);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 16,
  parameter int SEG_W   = 4,
  parameter int VPN_W   = 8,
  parameter int PPN_W   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [SEG_W-1:0] lk_seg,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_ready,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             wk_req,
  output logic [SEG_W-1:0] wk_seg,
  output logic [VPN_W-1:0] wk_vpn,
  input  logic             wk_rsp_valid,
  input  logic [PPN_W-1:0] wk_rsp_ppn,
  input  logic             wk_rsp_fault,
  output logic             res_valid,
  output logic [PPN_W-1:0] res_ppn,
  output logic             res_fault
);
  localparam int KEY_W = SEG_W + VPN_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [KEY_W-1:0]   lk_key, wk_key;
  logic               cam_hit, fill_en, touch;
  logic [IDX_W-1:0]   hit_idx, victim_idx, touch_idx;
  logic [PPN_W-1:0]   hit_ppn;
  logic [ENTRIES-1:0] valid_vec;

  assign lk_key = {lk_seg, lk_vpn};

  tlb_cam #(.N(ENTRIES), .KEY_W(KEY_W), .PPN_W(PPN_W)) u_cam (
    .clk(clk), .rst(rst), .flush(flush), .key(lk_key),
    .wr_en(fill_en), .wr_idx(victim_idx), .wr_key(wk_key), .wr_ppn(wk_rsp_ppn),
    .hit(cam_hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn), .valid_vec(valid_vec)
  );

  tlb_ctrl #(.KEY_W(KEY_W), .PPN_W(PPN_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_key(lk_key),
    .cam_hit(cam_hit), .rsp_valid(wk_rsp_valid), .rsp_ppn(wk_rsp_ppn),
    .rsp_fault(wk_rsp_fault), .lk_ready(lk_ready), .lk_miss(lk_miss),
    .wk_req(wk_req), .wk_key(wk_key), .fill_en(fill_en),
    .res_valid(res_valid), .res_ppn(res_ppn), .res_fault(res_fault)
  );

  assign lk_hit    = lk_ready && lk_valid && cam_hit && !flush;
  assign lk_ppn    = lk_hit ? hit_ppn : '0;
  assign touch     = lk_hit || fill_en;
  assign touch_idx = fill_en ? victim_idx : hit_idx;
  assign wk_seg    = wk_key[KEY_W-1 -: SEG_W];
  assign wk_vpn    = wk_key[VPN_W-1:0];

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .touch(touch), .touch_idx(touch_idx),
    .valid_vec(valid_vec), .victim_idx(victim_idx)
  );

  p_hit_no_miss_r1: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> !lk_miss);
  p_fault_no_install_r4: assert property (@(posedge clk) disable iff (rst)
    (wk_req && wk_rsp_valid && wk_rsp_fault && !flush) |=> $stable(valid_vec));
  p_busy_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !lk_ready |-> (!lk_hit && !lk_miss));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));
  p_flush_lookup_misses_r8: assert property (@(posedge clk) disable iff (rst)
    (flush && lk_valid && lk_ready) |-> lk_miss);
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        flush_tb, flush_wk;
  logic        flush;
  logic        lk_valid;
  logic [3:0]  lk_seg;
  logic [7:0]  lk_vpn;
  logic        lk_ready, lk_hit, lk_miss;
  logic [11:0] lk_ppn;
  logic        wk_req;
  logic [3:0]  wk_seg;
  logic [7:0]  wk_vpn;
  logic        wk_rsp_valid;
  logic [11:0] wk_rsp_ppn;
  logic        wk_rsp_fault;
  logic        res_valid;
  logic [11:0] res_ppn;
  logic        res_fault;

  int  total = 0;
  int  bad = 0;
  int  wdelay = 3;
  bit  fault_next = 1'b0;
  bit  flush_on_rsp = 1'b0;
  bit  done = 1'b0;

  assign flush = flush_tb | flush_wk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_fa u_tlb_fa (
    .clk(clk), .rst(rst), .flush(flush), .lk_valid(lk_valid), .lk_seg(lk_seg),
    .lk_vpn(lk_vpn), .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_ppn(lk_ppn), .wk_req(wk_req), .wk_seg(wk_seg), .wk_vpn(wk_vpn),
    .wk_rsp_valid(wk_rsp_valid), .wk_rsp_ppn(wk_rsp_ppn),
    .wk_rsp_fault(wk_rsp_fault), .res_valid(res_valid), .res_ppn(res_ppn),
    .res_fault(res_fault)
  );

  function automatic logic [11:0] xlate(logic [3:0] s, logic [7:0] v);
    return {s, v} ^ 12'h5A3;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // walker model: variable delay, optional fault, optional flush on the response edge
  initial begin
    wk_rsp_valid = 1'b0;
    wk_rsp_ppn   = '0;
    wk_rsp_fault = 1'b0;
    flush_wk     = 1'b0;
    forever begin
      @(negedge clk);
      if (wk_req) begin
        repeat (wdelay) @(negedge clk);
        wk_rsp_ppn   = xlate(wk_seg, wk_vpn);
        wk_rsp_fault = fault_next;
        wk_rsp_valid = 1'b1;
        flush_wk     = flush_on_rsp;
        @(negedge clk);
        wk_rsp_valid = 1'b0;
        flush_wk     = 1'b0;
      end
    end
  end

  task automatic wait_res(input logic [3:0] s, input logic [7:0] v, input string tag);
    int n = 0;
    while (!res_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " res_valid"}, res_valid, 1);
    chk({tag, " res_ppn"}, res_ppn, xlate(s, v));
    chk({tag, " res_fault"}, res_fault, fault_next);
    chk({tag, " ready after result"}, lk_ready, 1);
  endtask

  task automatic lookup(input logic [3:0] s, input logic [7:0] v, input bit exp_hit,
                        input string tag);
    @(negedge clk);
    lk_valid = 1'b1; lk_seg = s; lk_vpn = v;
    #1;
    if (exp_hit) begin
      chk({tag, " hit"}, lk_hit, 1);
      chk({tag, " ppn"}, lk_ppn, xlate(s, v));
      chk({tag, " no miss"}, lk_miss, 0);
    end else begin
      chk({tag, " miss"}, lk_miss, 1);
      chk({tag, " no hit"}, lk_hit, 0);
    end
    @(posedge clk);
    #1 lk_valid = 1'b0;
    if (exp_hit) chk({tag, " no walk after hit"}, wk_req, 0);
    else begin
      chk({tag, " walk key"}, {wk_req, wk_seg, wk_vpn}, {1'b1, s, v});
      wait_res(s, v, tag);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); flush_tb = 1'b1;
    @(negedge clk); flush_tb = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 ready", lk_ready, 1);
    chk("R10 no req", wk_req, 0);
    chk("R10 no res", res_valid, 0);
    lookup(4'h0, 8'h00, 0, "R10 empty after reset");
  endtask

  task automatic t_basic();
    lookup(4'h3, 8'h21, 0, "R2 first access");
    lookup(4'h3, 8'h21, 1, "R1 R3 hit after fill");
    lookup(4'h3, 8'h22, 0, "R2 neighbour page");
    lookup(4'h4, 8'h21, 0, "R2 other segment");
    lookup(4'h3, 8'h22, 1, "R1 neighbour hit");
  endtask

  task automatic t_busy();
    wdelay = 20;
    @(negedge clk);
    lk_valid = 1'b1; lk_seg = 4'h7; lk_vpn = 8'h70;
    @(posedge clk); #1;
    lk_seg = 4'h3; lk_vpn = 8'h21;   // resident key presented while busy
    repeat (5) @(negedge clk);
    chk("R5 not ready", lk_ready, 0);
    chk("R5 no hit", lk_hit, 0);
    chk("R5 no miss", lk_miss, 0);
    chk("R2 key held", {wk_req, wk_seg, wk_vpn}, {1'b1, 4'h7, 8'h70});
    lk_valid = 1'b0;
    wait_res(4'h7, 8'h70, "R2 long walk");
    wdelay = 3;
    lookup(4'h7, 8'h70, 1, "R3 long walk installed");
  endtask

  task automatic t_fault();
    fault_next = 1'b1;
    lookup(4'h9, 8'h99, 0, "R4 fault walk");
    fault_next = 1'b0;
    lookup(4'h9, 8'h99, 0, "R4 not installed");
    lookup(4'h9, 8'h99, 1, "R4 retry installed");
  endtask

  task automatic t_flush();
    lookup(4'h5, 8'h01, 0, "R8 prep");
    lookup(4'h5, 8'h01, 1, "R8 prep hit");
    // lookup in the flush cycle
    @(negedge clk);
    flush_tb = 1'b1; lk_valid = 1'b1; lk_seg = 4'h5; lk_vpn = 8'h01;
    #1;
    chk("R8 flush-cycle miss", lk_miss, 1);
    chk("R8 flush-cycle no hit", lk_hit, 0);
    @(posedge clk); #1;
    flush_tb = 1'b0; lk_valid = 1'b0;
    wait_res(4'h5, 8'h01, "R8 flush walk");
    lookup(4'h3, 8'h21, 0, "R8 old entry gone");
    lookup(4'h5, 8'h01, 1, "R8 refill hit");
  endtask

  task automatic t_flush_rsp();
    flush_on_rsp = 1'b1;
    lookup(4'hA, 8'h0A, 0, "R9 walk with flush");
    flush_on_rsp = 1'b0;
    lookup(4'hA, 8'h0A, 0, "R9 not installed");
  endtask

  task automatic t_lru();
    do_flush();
    for (int i = 0; i < N; i++) lookup(4'h1, 8'(i), 0, "R6 fill");
    for (int i = 0; i < N; i++) lookup(4'h1, 8'(i), 1, "R6 all resident");
    lookup(4'h1, 8'd0, 1, "R7 touch oldest");
    lookup(4'h2, 8'd0, 0, "R7 new key evicts");
    lookup(4'h1, 8'd0, 1, "R7 touched survives");
    lookup(4'h1, 8'd2, 1, "R7 next survives");
    lookup(4'h2, 8'd0, 1, "R7 new key resident");
    lookup(4'h1, 8'd1, 0, "R7 LRU was evicted");
    lookup(4'h1, 8'd3, 0, "R7 next LRU evicted");
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    rst = 1'b1; flush_tb = 1'b0; lk_valid = 1'b0; lk_seg = '0; lk_vpn = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_busy();
    t_fault();
    t_flush();
    t_flush_rsp();
    t_lru();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule